// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block moves a single switchable power island between its on and off states. Turning the island off is a fixed sequence. The block first asks the island's bus interface to go quiet, then waits for that interface to confirm, and only then opens the power switch. Turning the island on runs the same steps in reverse. The switch is closed first, the block waits until the island reports power, and then it withdraws the quiesce request and waits for the interface to confirm that it has resumed.

Each step that waits on the island runs under its own timeout. When the timeout expires, the block reports a one-cycle error and returns to rest. A command that asks for the state the island is already in completes at once and changes nothing.

After each switch change the block counts a programmable settle time before it polls the power status. There are two settle words: one for power-down, selected by `cfg_sel_i = 0`, and one for power-up, selected by `cfg_sel_i = 1`. Parameters choose what the island has: a quiesce handshake only, a power switch only, or both. A parameter also chooses whether a power-status input exists.

Top module: `pds_seq`

## Requirements
- R1: On a power-off command, `idle_req_o` goes to 1. The block waits until `idle_ack_i` is 1 and then until `idle_stat_i` is 1. Only after that does `pwr_off_o` go to 1.
- R2: On a power-on command, `pwr_off_o` goes to 0. The block waits until the island reports on, and only then drops `idle_req_o` to 0. It then waits for `idle_ack_i` = 0 and after that for `idle_stat_i` = 0, and only then completes.
- R3: Polarities are as follows. `idle_req_o` = 1 requests quiesce. `pwr_off_o` = 1 opens the power switch. `pwr_stat_i` = 1 means the island is off and 0 means it is on.
- R4: With `HAS_STATUS` = 0, the island counts as on exactly when `idle_stat_i` is 0.
- R5: With `HAS_IDLE_REQ` = 0, the handshake steps are skipped and `idle_req_o` stays 0. With `HAS_PWR` = 0, the switch and settle steps are skipped and `pwr_off_o` stays 0.
- R6: Each wait step may last at most CLK_MHZ*TIMEOUT_US cycles. When a wait step starts and its condition never holds, `err_o` pulses for one cycle exactly that many cycles after the step begins. `busy_o` then drops, `done_o` does not pulse, and `idle_req_o` and `pwr_off_o` keep their last driven values.
- R7: There are two settle words, both reset to DEF_SETTLE. A write with `cfg_sel_i` = 0 loads the power-down word and a write with `cfg_sel_i` = 1 loads the power-up word. For a settle value S, `pwr_off_o` changes, and the next step follows S+2 cycles later. On power-down the next step is the `done_o` pulse; on power-up it is the fall of `idle_req_o`.
- R8: A command whose target already matches the island's state pulses `done_o` in the next cycle. It never raises `busy_o` and leaves both control outputs unchanged.
- R9: While `busy_o` is 1, `cmd_valid_i` is ignored. No second transition follows the current one.
- R10: `busy_o` is 1 from the cycle after an accepted command until completion. Completion is marked by a one-cycle `done_o` pulse.
- R11: After reset, `idle_req_o`, `pwr_off_o`, `busy_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, sampled only while the block is at rest |
| cmd_on_i | input | 1 | Target state: 1 for on, 0 for off |
| idle_ack_i | input | 1 | Bus interface acknowledge of the quiesce request |
| idle_stat_i | input | 1 | Bus interface reports that it is quiet |
| pwr_stat_i | input | 1 | Island power status (1 = off) |
| cfg_wr_i | input | 1 | Settle word write strobe |
| cfg_sel_i | input | 1 | Settle word select (0 = down, 1 = up) |
| cfg_data_i | input | CNT_W | Settle value to write |
| idle_req_o | output | 1 | Quiesce request to the bus interface |
| pwr_off_o | output | 1 | Power switch control (1 = open) |
| busy_o | output | 1 | A transition is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |

## Verification
The hardest situations to reach are those where the island holds one handshake or status line at a wrong value during one particular step. The same hold must then be released before the next command, so the sequencer starts from the odd leftover state: an island that is powered but still quiesced. The bench drives an island model whose acknowledge, idle and power-status paths can each be frozen for a single table entry. The following entries then check that the block sees a powered-but-quiesced island as already on. They also check that a later power-down proceeds at once from the request level already in place.

// File: rtl/pds_pkg.sv
package pds_pkg;

   // Sequencer phases
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ACK    = 3'd1,
      ST_QUIET  = 3'd2,
      ST_SETTLE = 3'd3,
      ST_PWR    = 3'd4
   } pds_state_e;

   // Settle word selection
   localparam int unsigned PDS_WORDS  = 2;
   localparam logic        PDS_SEL_DN = 1'b0;
   localparam logic        PDS_SEL_UP = 1'b1;

endpackage

// File: rtl/pds_settle_regs.sv
module pds_settle_regs #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DEF_SETTLE = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_wr_i,
   input  logic             cfg_sel_i,
   input  logic [CNT_W-1:0] cfg_data_i,
   output logic [CNT_W-1:0] dn_settle_o,
   output logic [CNT_W-1:0] up_settle_o
);
   import pds_pkg::*;

   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(DEF_SETTLE);

   for (genvar w = 0; w < PDS_WORDS; w++) begin : g_word
      localparam logic MY_SEL = (w == 1) ? PDS_SEL_UP : PDS_SEL_DN;
      logic [CNT_W-1:0] val_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            val_q <= RST_VAL;
         end else if (cfg_wr_i && (cfg_sel_i == MY_SEL)) begin
            val_q <= cfg_data_i;
         end
      end
   end

   assign dn_settle_o = g_word[0].val_q;
   assign up_settle_o = g_word[1].val_q;

   // R7: a write lands only in the selected word
   assert_cfg_dn_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && cfg_sel_i == PDS_SEL_DN) |=> (dn_settle_o == $past(cfg_data_i)) && $stable(up_settle_o));
   assert_cfg_up_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && cfg_sel_i == PDS_SEL_UP) |=> (up_settle_o == $past(cfg_data_i)) && $stable(dn_settle_o));

endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
   parameter int unsigned TO_CYC = 500000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic run_i,
   output logic expired_o
);
   localparam int unsigned TW = $clog2(TO_CYC + 1);
   localparam logic [TW-1:0] LAST = TW'(TO_CYC - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = run_i && (cnt_q == LAST);

   // R6: the phase counter never passes its limit
   assert_timer_bound_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm #(
   parameter int unsigned CNT_W        = 16,
   parameter bit          HAS_IDLE_REQ = 1'b1,
   parameter bit          HAS_PWR      = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmd_valid_i,
   input  logic             cmd_on_i,
   input  logic             is_on_i,
   input  logic             ack_i,
   input  logic             quiet_i,
   input  logic [CNT_W-1:0] dn_settle_i,
   input  logic [CNT_W-1:0] up_settle_i,
   input  logic             to_expired_i,
   output logic             idle_req_o,
   output logic             pwr_off_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic             to_run_o,
   output logic             to_clr_o
);
   import pds_pkg::*;

   pds_state_e       state_q, state_d;
   logic             goal_q, goal_d;
   logic             req_q, req_d;
   logic             off_q, off_d;
   logic             done_q, done_d;
   logic             err_q, err_d;
   logic [CNT_W-1:0] sc_q, sc_d;
   logic             want;

   // Handshake level expected back from the island equals the request level
   assign want = ~goal_q;

   always_comb begin
      state_d = state_q;
      goal_d  = goal_q;
      req_d   = req_q;
      off_d   = off_q;
      sc_d    = sc_q;
      done_d  = 1'b0;
      err_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cmd_valid_i) begin
               if (is_on_i == cmd_on_i) begin
                  done_d = 1'b1;
               end else begin
                  goal_d = cmd_on_i;
                  if (!cmd_on_i) begin
                     if (HAS_IDLE_REQ) begin
                        req_d   = 1'b1;
                        state_d = ST_ACK;
                     end else begin
                        off_d   = 1'b1;
                        sc_d    = dn_settle_i;
                        state_d = ST_SETTLE;
                     end
                  end else begin
                     if (HAS_PWR) begin
                        off_d   = 1'b0;
                        sc_d    = up_settle_i;
                        state_d = ST_SETTLE;
                     end else begin
                        req_d   = 1'b0;
                        state_d = ST_ACK;
                     end
                  end
               end
            end
         end
         ST_ACK: begin
            if (ack_i == want) begin
               state_d = ST_QUIET;
            end else if (to_expired_i) begin
               err_d   = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_QUIET: begin
            if (quiet_i == want) begin
               if (!goal_q && HAS_PWR) begin
                  off_d   = 1'b1;
                  sc_d    = dn_settle_i;
                  state_d = ST_SETTLE;
               end else begin
                  done_d  = 1'b1;
                  state_d = ST_IDLE;
               end
            end else if (to_expired_i) begin
               err_d   = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_SETTLE: begin
            if (sc_q == '0) begin
               state_d = ST_PWR;
            end else begin
               sc_d = sc_q - 1'b1;
            end
         end
         ST_PWR: begin
            if (is_on_i == goal_q) begin
               if (goal_q && HAS_IDLE_REQ) begin
                  req_d   = 1'b0;
                  state_d = ST_ACK;
               end else begin
                  done_d  = 1'b1;
                  state_d = ST_IDLE;
               end
            end else if (to_expired_i) begin
               err_d   = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         goal_q  <= 1'b1;
         req_q   <= 1'b0;
         off_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         sc_q    <= '0;
      end else begin
         state_q <= state_d;
         goal_q  <= goal_d;
         req_q   <= req_d;
         off_q   <= off_d;
         done_q  <= done_d;
         err_q   <= err_d;
         sc_q    <= sc_d;
      end
   end

   assign idle_req_o = req_q;
   assign pwr_off_o  = off_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign to_run_o   = (state_q == ST_ACK) || (state_q == ST_QUIET) || (state_q == ST_PWR);
   assign to_clr_o   = (state_d != state_q) || (state_q == ST_IDLE);

   // R6: an error only ends a supervised wait step
   assert_err_wait_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> ($past(state_q) == ST_ACK) || ($past(state_q) == ST_QUIET) || ($past(state_q) == ST_PWR));
   // R6: an error is never reported together with completion
   assert_err_nodone_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> !done_o);
   // R7: settle phase lasts until its count reaches zero
   assert_settle_len_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_SETTLE && sc_q != '0) |=> (state_q == ST_SETTLE));
   // R8: a command for the present state finishes at once
   assert_already_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && cmd_valid_i && is_on_i == cmd_on_i) |=> (done_o && !busy_o && $stable(req_q) && $stable(off_q)));
   // R9: a command during a transition does not retarget it
   assert_busy_hold_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && cmd_valid_i) |=> $stable(goal_q));

endmodule

// File: rtl/pds_seq.sv
module pds_seq #(
   parameter int unsigned CLK_MHZ      = 50,
   parameter int unsigned TIMEOUT_US   = 10000,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned DEF_SETTLE   = 24,
   parameter bit          HAS_IDLE_REQ = 1'b1,
   parameter bit          HAS_PWR      = 1'b1,
   parameter bit          HAS_STATUS   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmd_valid_i,
   input  logic             cmd_on_i,
   input  logic             idle_ack_i,
   input  logic             idle_stat_i,
   input  logic             pwr_stat_i,
   input  logic             cfg_wr_i,
   input  logic             cfg_sel_i,
   input  logic [CNT_W-1:0] cfg_data_i,
   output logic             idle_req_o,
   output logic             pwr_off_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   localparam int unsigned TO_CYC = CLK_MHZ * TIMEOUT_US;

   // Elaboration-time parameter checks
   if (!HAS_IDLE_REQ && !HAS_PWR) begin : g_chk_caps
      $error("pds_seq: island needs a handshake or a switch");
   end
   if (HAS_PWR && !HAS_STATUS) begin : g_chk_stat
      $error("pds_seq: a switched island needs a status input");
   end
   if (TO_CYC < 2) begin : g_chk_to
      $error("pds_seq: timeout too short");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_chk_w
      $error("pds_seq: settle width out of range");
   end

   logic             is_on;
   logic             req_raw, off_raw;
   logic             to_run, to_clr, to_exp;
   logic [CNT_W-1:0] dn_settle, up_settle;

   // Power state source
   if (HAS_STATUS) begin : g_on_stat
      assign is_on = ~pwr_stat_i;
   end else begin : g_on_idle
      assign is_on = ~idle_stat_i;
   end

   pds_settle_regs #(
      .CNT_W      (CNT_W),
      .DEF_SETTLE (DEF_SETTLE)
   ) settle_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_wr_i    (cfg_wr_i),
      .cfg_sel_i   (cfg_sel_i),
      .cfg_data_i  (cfg_data_i),
      .dn_settle_o (dn_settle),
      .up_settle_o (up_settle)
   );

   pds_timer #(
      .TO_CYC (TO_CYC)
   ) timer_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (to_clr),
      .run_i     (to_run),
      .expired_o (to_exp)
   );

   pds_fsm #(
      .CNT_W        (CNT_W),
      .HAS_IDLE_REQ (HAS_IDLE_REQ),
      .HAS_PWR      (HAS_PWR)
   ) fsm_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cmd_valid_i  (cmd_valid_i),
      .cmd_on_i     (cmd_on_i),
      .is_on_i      (is_on),
      .ack_i        (idle_ack_i),
      .quiet_i      (idle_stat_i),
      .dn_settle_i  (dn_settle),
      .up_settle_i  (up_settle),
      .to_expired_i (to_exp),
      .idle_req_o   (req_raw),
      .pwr_off_o    (off_raw),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .err_o        (err_o),
      .to_run_o     (to_run),
      .to_clr_o     (to_clr)
   );

   // Capability tie-offs
   if (HAS_IDLE_REQ) begin : g_req
      assign idle_req_o = req_raw;
   end else begin : g_no_req
      assign idle_req_o = 1'b0;
   end
   if (HAS_PWR) begin : g_pwr
      assign pwr_off_o = off_raw;
   end else begin : g_no_pwr
      assign pwr_off_o = 1'b0;
   end

   // R11: outputs at rest right after reset
   assert_reset_R11 : assert property (@(posedge clk_i)
      $rose(rst_ni) |-> !busy_o && !done_o && !err_o);

   if (HAS_IDLE_REQ && HAS_PWR) begin : g_order_chk
      // R1: the switch opens only after acknowledge and quiet were seen
      assert_down_order_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(pwr_off_o) |-> idle_req_o && $past(idle_ack_i) && $past(idle_stat_i));
      // R2: quiesce is withdrawn only once power is back
      assert_up_order_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(idle_req_o) |-> !pwr_off_o && !$past(pwr_stat_i));
   end

endmodule

// File: tb/pds_seq_tb_top.sv
module pds_island_model (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic       off_i,
   input  logic [2:0] adly,
   input  logic [2:0] idly,
   input  logic       stuck_ack,
   input  logic       stuck_idl,
   input  logic       stuck_pwr,
   output logic       ack_o,
   output logic       idl_o,
   output logic       pst_o
);
   logic [2:0] ac, ic;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o <= 1'b0; idl_o <= 1'b0; pst_o <= 1'b0; ac <= '0; ic <= '0;
      end else begin
         if (!stuck_ack && ack_o != req_i) begin
            if (ac >= adly) begin ack_o <= req_i; ac <= '0; end
            else ac <= ac + 3'd1;
         end else ac <= '0;
         if (!stuck_idl && idl_o != ack_o) begin
            if (ic >= idly) begin idl_o <= ack_o; ic <= '0; end
            else ic <= ic + 3'd1;
         end else ic <= '0;
         if (!stuck_pwr) pst_o <= off_i;
      end
   end
endmodule

module pds_seq_tb_top;
   localparam int CLK_MHZ = 50;
   localparam int TO_US   = 2;
   localparam int TO_CYC  = CLK_MHZ * TO_US;
   localparam int LIMIT   = 1000;

   typedef struct packed {
      logic       on;
      logic [2:0] adly;
      logic [2:0] idly;
      logic [1:0] stuck;   // 0 none, 1 ack, 2 idle, 3 power status
      logic       exp_err;
      logic       exp_req;
      logic       exp_off;
      logic       exp_busy;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd2, 3'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{1'b1, 3'd1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{1'b1, 3'd4, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{1'b1, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{1'b0, 3'd1, 3'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},
      '{1'b0, 3'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{1'b1, 3'd1, 3'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
      '{1'b1, 3'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{1'b1, 3'd2, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{1'b0, 3'd1, 3'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
      '{1'b1, 3'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{1'b0, 3'd1, 3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{1'b1, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic cv [3];
   logic con [3];
   logic req [3], off [3], busy [3], done [3], err [3];
   logic ack [3], idl [3], pst [3];
   logic [2:0] adly, idly;
   logic s_ack, s_idl, s_pwr;
   logic cfg_wr, cfg_sel;
   logic [15:0] cfg_data;

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   pds_seq #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TO_US)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[0]), .cmd_on_i(con[0]),
      .idle_ack_i(ack[0]), .idle_stat_i(idl[0]), .pwr_stat_i(pst[0]),
      .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
      .idle_req_o(req[0]), .pwr_off_o(off[0]), .busy_o(busy[0]), .done_o(done[0]), .err_o(err[0]));

   pds_seq #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TO_US), .HAS_PWR(1'b0), .HAS_STATUS(1'b0)) dut_idle_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[1]), .cmd_on_i(con[1]),
      .idle_ack_i(ack[1]), .idle_stat_i(idl[1]), .pwr_stat_i(pst[1]),
      .cfg_wr_i(1'b0), .cfg_sel_i(1'b0), .cfg_data_i(16'd0),
      .idle_req_o(req[1]), .pwr_off_o(off[1]), .busy_o(busy[1]), .done_o(done[1]), .err_o(err[1]));

   pds_seq #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TO_US), .HAS_IDLE_REQ(1'b0)) dut_pwr_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[2]), .cmd_on_i(con[2]),
      .idle_ack_i(ack[2]), .idle_stat_i(idl[2]), .pwr_stat_i(pst[2]),
      .cfg_wr_i(1'b0), .cfg_sel_i(1'b0), .cfg_data_i(16'd0),
      .idle_req_o(req[2]), .pwr_off_o(off[2]), .busy_o(busy[2]), .done_o(done[2]), .err_o(err[2]));

   for (genvar u = 0; u < 3; u++) begin : g_isl
      pds_island_model isl_i (
         .clk(clk), .rst_n(rst_n), .req_i(req[u]), .off_i(off[u]), .adly(adly), .idly(idly),
         .stuck_ack((u == 0) ? s_ack : 1'b0), .stuck_idl((u == 0) ? s_idl : 1'b0),
         .stuck_pwr((u == 0) ? s_pwr : 1'b0),
         .ack_o(ack[u]), .idl_o(idl[u]), .pst_o(pst[u]));
   end

   // Ordering monitors on the full island
   logic prev_off = 1'b0, prev_req = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (off[0] && !prev_off)
            check(req[0] && ack[0] && idl[0], "R1 switch opened before handshake",
                  {req[0], ack[0], idl[0]}, 7);
         if (!req[0] && prev_req)
            check(!off[0] && !pst[0], "R2 request dropped before power on",
                  {off[0], pst[0]}, 0);
      end
      prev_off <= off[0];
      prev_req <= req[0];
   end

   task automatic run_cmd(input int u, input bit on, output bit sd, output bit se, output bit sb,
                          output int t_end, output int t_off, output int t_rf);
      bit off0, rp;
      @(negedge clk);
      off0 = off[u];
      rp = req[u];
      cv[u] = 1'b1;
      con[u] = on;
      @(negedge clk);
      cv[u] = 1'b0;
      sd = 0; se = 0; sb = 0; t_end = -1; t_off = -1; t_rf = -1;
      for (int i = 0; i < LIMIT; i++) begin
         if (busy[u]) sb = 1;
         if (t_off < 0 && off[u] != off0) t_off = i;
         if (t_rf < 0 && rp && !req[u]) t_rf = i;
         rp = req[u];
         if (done[u]) begin sd = 1; t_end = i; break; end
         if (err[u]) begin se = 1; t_end = i; break; end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit sd, se, sb;
      int te, to, trf;
      for (int u = 0; u < 3; u++) begin cv[u] = 1'b0; con[u] = 1'b0; end
      adly = 3'd1; idly = 3'd1; s_ack = 0; s_idl = 0; s_pwr = 0;
      cfg_wr = 0; cfg_sel = 0; cfg_data = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(!req[0] && !off[0] && !busy[0] && !done[0] && !err[0], "R11 reset outputs",
            {req[0], off[0], busy[0], done[0], err[0]}, 0);

      // Vector walk on the full island
      for (int v = 0; v < NV; v++) begin
         adly = VECS[v].adly; idly = VECS[v].idly;
         s_ack = (VECS[v].stuck == 2'd1);
         s_idl = (VECS[v].stuck == 2'd2);
         s_pwr = (VECS[v].stuck == 2'd3);
         run_cmd(0, VECS[v].on, sd, se, sb, te, to, trf);
         check(se == VECS[v].exp_err, $sformatf("R6 vec%0d error", v), se, VECS[v].exp_err);
         check(sd == !VECS[v].exp_err, $sformatf("R10 vec%0d done", v), sd, !VECS[v].exp_err);
         check(req[0] == VECS[v].exp_req, $sformatf("R3 vec%0d idle_req", v), req[0], VECS[v].exp_req);
         check(off[0] == VECS[v].exp_off, $sformatf("R3 vec%0d pwr_off", v), off[0], VECS[v].exp_off);
         check(sb == VECS[v].exp_busy, $sformatf("R8 vec%0d busy seen", v), sb, VECS[v].exp_busy);
         if (VECS[v].stuck == 2'd1)
            check(te == TO_CYC, "R6 timeout cycle", te, TO_CYC);
         @(negedge clk);
         check(!busy[0] && !done[0], "R10 single pulse", {busy[0], done[0]}, 0);
         s_ack = 0; s_idl = 0; s_pwr = 0;
         repeat (4) @(negedge clk);
      end

      // R7 default settle on power-down
      adly = 3'd1; idly = 3'd1;
      run_cmd(0, 1'b0, sd, se, sb, te, to, trf);
      check(te - to == 26, "R7 default down settle", te - to, 26);
      // R7 program both words
      @(negedge clk); cfg_wr = 1; cfg_sel = 0; cfg_data = 16'd5;
      @(negedge clk); cfg_sel = 1; cfg_data = 16'd3;
      @(negedge clk); cfg_wr = 0;
      run_cmd(0, 1'b1, sd, se, sb, te, to, trf);
      check(trf - to == 5, "R7 up settle", trf - to, 5);
      check(sd && !req[0] && !off[0], "R2 power-up completes", {sd, req[0], off[0]}, 4);
      run_cmd(0, 1'b0, sd, se, sb, te, to, trf);
      check(te - to == 7, "R7 down settle", te - to, 7);

      // R9 command while busy is ignored
      run_cmd(0, 1'b1, sd, se, sb, te, to, trf);
      @(negedge clk); cv[0] = 1; con[0] = 0;
      @(negedge clk); cv[0] = 0;
      repeat (2) @(negedge clk);
      check(busy[0], "R10 busy during transition", busy[0], 1);
      cv[0] = 1; con[0] = 1;
      @(negedge clk); cv[0] = 0;
      begin
         int guard = 0;
         while (!done[0] && guard < LIMIT) begin @(negedge clk); guard++; end
      end
      check(req[0] && off[0], "R9 first command wins", {req[0], off[0]}, 3);
      begin
         bit extra = 0;
         repeat (40) begin @(negedge clk); if (busy[0] || done[0]) extra = 1; end
         check(!extra, "R9 no queued transition", extra, 0);
      end

      // Idle-only island
      run_cmd(1, 1'b1, sd, se, sb, te, to, trf);
      check(sd && !sb, "R4 idle-only island starts on", {sd, sb}, 2);
      run_cmd(1, 1'b0, sd, se, sb, te, to, trf);
      check(sd && req[1] && ack[1] && idl[1], "R4 idle-only power-down", {sd, req[1], ack[1], idl[1]}, 15);
      check(!off[1], "R5 no switch on idle-only island", off[1], 0);
      run_cmd(1, 1'b0, sd, se, sb, te, to, trf);
      check(sd && !sb, "R4 quiet island counts as off", {sd, sb}, 2);
      run_cmd(1, 1'b1, sd, se, sb, te, to, trf);
      check(sd && !req[1] && !idl[1], "R4 idle-only power-up", {sd, req[1], idl[1]}, 4);

      // Power-only island
      run_cmd(2, 1'b0, sd, se, sb, te, to, trf);
      check(sd && off[2] && !req[2], "R5 power-only down", {sd, off[2], req[2]}, 6);
      check(te - to == 26, "R5 power-only settle", te - to, 26);
      run_cmd(2, 1'b1, sd, se, sb, te, to, trf);
      check(sd && !off[2] && !req[2], "R5 power-only up", {sd, off[2], req[2]}, 4);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule